// File: doc/BRIEF.md
# Indexed Register Window with Run-Control Sequencer

This block is the slave-side register window of a network controller. Software reaches the registers indirectly. It first writes a register number into an index port. It then reads or writes the selected control/status register through one data port, or the selected bus-configuration register through a second data port. A read of a separate port acts as a soft reset. All ports are 16 bits wide and sit at fixed byte offsets inside a small address window.

Control register 0 holds the run-control sequencer, which has four states: stopped, initialising, initialised and running. It accepts one-shot commands, reports its state, and keeps a sticky init-done flag that software clears by writing a one. The fetch of the initialisation block is not part of this block. It is represented by a request/acknowledge pair. Control registers 1 and 2 form the 32-bit address of the initialisation block, and that address is also driven out. A start command in the running state can raise a one-cycle transmit-demand pulse. Control registers 88 and 89 return a constant 32-bit identification word.

Top module: `regwin_ctl`

## Requirements
- R1: A write to the index port (byte offset 0x12) stores the low IDX_W bits (7 by default) of the written data. A read of that port returns the stored value zero-extended: writing 88 reads back 88, and writing 0xFFFF reads back 0x007F.
- R2: After the reset input, control register 0 reads exactly 0x0004 and init_req, run and tx_demand are low. Bit 2 means stopped, bit 1 means running, bit 0 means initialising and bit 8 means init done.
- R3: Writing 1 to bit 0 of control register 0, through the register data port at 0x10 with index 0, enters the initialising state from any other state. In that state init_req is high and register 0 reads 0x0001 while init done is clear. init_req and run are never high together.
- R4: While initialising, a cycle with init_ack high moves the block to the initialised state. On the same edge init_req falls and the init-done bit (0x0100) is set.
- R5: Writing a one to bit 8 of register 0 clears init done. Writing zero there leaves it unchanged. Command bits are never stored and read back as state only.
- R6: Writing 1 to bit 1 of register 0 enters the running state from any state except initialising. run goes high and register 0 reads bit 1 set.
- R7: Writing 1 to bit 3 of register 0 while running makes tx_demand high for exactly the one cycle after the write. When the block is not running, the write has no effect.
- R8: Writing 1 to bit 2 of register 0 stops the block from any state and drops init_req and run. Within one write, stop beats init and init beats start (0x0007 gives 0x0004, and 0x0003 from stopped gives 0x0001).
- R9: Control registers 1 and 2 are read/write and hold the low and high halves of init_addr.
- R10: Control register 88 reads {PART_CODE[3:0], 12'h003} and register 89 reads {4'h0, PART_CODE[15:4]}. With the default PART_CODE of 0x2625 these are 0x5003 and 0x0262. Writes to them are ignored.
- R11: A read of the reset port (0x14) returns 0. It puts the block in the stopped state with init done clear, so register 0 reads 0x0004. Registers 1 and 2 keep their values.
- R12: Through the bus-configuration port (0x16), each index below BCR_COUNT (34 by default) is a 16-bit read/write register that resets to zero.
- R13: Unimplemented control-register indices and bus-configuration indices at or above BCR_COUNT read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Window select for the current access |
| wr | input | 1 | Write strobe, one cycle per access |
| rd | input | 1 | Read strobe, one cycle per access |
| addr | input | AW (5) | Byte offset within the window |
| wdata | input | DW (16) | Write data |
| rdata | output | DW (16) | Read data, combinational, zero when no read |
| init_ack | input | 1 | Initialisation-block fetch finished |
| init_req | output | 1 | Request to fetch the initialisation block |
| init_addr | output | 2*DW (32) | Initialisation-block address {reg2, reg1} |
| run | output | 1 | Block is in the running state |
| tx_demand | output | 1 | One-cycle transmit-poll pulse |

## Verification
The properties assume that wr and rd are never asserted together. They also assume that every access lasts exactly one clock with sel held, and that init_ack is pulsed only as an answer to init_req. The bench drives each access for a single cycle and leaves idle cycles between accesses. It raises init_ack only after it has seen init_req high. Its random phase only targets data registers, index values and bus-configuration indices, some of them beyond BCR_COUNT, so the sequencer is moved only by the directed steps.

// File: rtl/rw_pkg.sv
package rw_pkg;
   typedef enum logic [1:0] {
      RS_STOP = 2'd0,
      RS_INIT = 2'd1,
      RS_IDLE = 2'd2,
      RS_RUN  = 2'd3
   } run_state_t;

   // byte offsets of the four ports
   localparam logic [7:0] OFF_DATA = 8'h10;
   localparam logic [7:0] OFF_IDX  = 8'h12;
   localparam logic [7:0] OFF_RST  = 8'h14;
   localparam logic [7:0] OFF_BCFG = 8'h16;

   // control register 0 bit positions
   localparam int B_INIT = 0;
   localparam int B_STRT = 1;
   localparam int B_STOP = 2;
   localparam int B_TDMD = 3;
   localparam int B_IDON = 8;

   // control register indices
   localparam int CR_MAIN  = 0;
   localparam int CR_ADRLO = 1;
   localparam int CR_ADRHI = 2;
   localparam int CR_IDLO  = 88;
   localparam int CR_IDHI  = 89;

   localparam logic [11:0] ID_TAG = 12'h003;
endpackage

// File: rtl/rw_run_ctl.sv
module rw_run_ctl
   import rw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic cmd_wr,
   input  logic cmd_init,
   input  logic cmd_strt,
   input  logic cmd_stop,
   input  logic cmd_tdmd,
   input  logic cmd_idclr,
   input  logic init_ack,
   output run_state_t state,
   output logic idon,
   output logic init_req,
   output logic run,
   output logic tx_demand
);
   logic ack_hit;
   assign ack_hit = (state == RS_INIT) && init_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RS_STOP;
         idon      <= 1'b0;
         tx_demand <= 1'b0;
      end else if (soft_rst) begin
         state     <= RS_STOP;
         idon      <= 1'b0;
         tx_demand <= 1'b0;
      end else begin
         tx_demand <= cmd_wr && cmd_tdmd && (state == RS_RUN);
         if (cmd_wr && cmd_stop)
            state <= RS_STOP;
         else if (cmd_wr && cmd_init && state != RS_INIT)
            state <= RS_INIT;
         else if (cmd_wr && cmd_strt && state != RS_INIT)
            state <= RS_RUN;
         else if (ack_hit)
            state <= RS_IDLE;
         idon <= ack_hit || (idon && !(cmd_wr && cmd_idclr));
      end
   end

   assign init_req = (state == RS_INIT);
   assign run      = (state == RS_RUN);
endmodule

// File: rtl/rw_bcr_bank.sv
module rw_bcr_bank #(
   parameter int DW        = 16,
   parameter int IDX_W     = 7,
   parameter int BCR_COUNT = 34
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [DW-1:0]    wdata,
   output logic [DW-1:0]    rdata
);
   logic [DW-1:0] regs [BCR_COUNT];

   for (genvar g = 0; g < BCR_COUNT; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[g] <= '0;
         else if (wr_en && idx == IDX_W'(g))
            regs[g] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < BCR_COUNT; i++)
         if (idx == IDX_W'(i)) rdata = regs[i];
   end
endmodule

// File: rtl/regwin_ctl.sv
module regwin_ctl
   import rw_pkg::*;
#(
   parameter int          DW        = 16,
   parameter int          AW        = 5,
   parameter int          IDX_W     = 7,
   parameter int          BCR_COUNT = 34,
   parameter logic [15:0] PART_CODE = 16'h2625
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sel,
   input  logic            wr,
   input  logic            rd,
   input  logic [AW-1:0]   addr,
   input  logic [DW-1:0]   wdata,
   output logic [DW-1:0]   rdata,
   input  logic            init_ack,
   output logic            init_req,
   output logic [2*DW-1:0] init_addr,
   output logic            run,
   output logic            tx_demand
);
   localparam logic [AW-1:0] A_DATA = AW'(OFF_DATA);
   localparam logic [AW-1:0] A_IDX  = AW'(OFF_IDX);
   localparam logic [AW-1:0] A_RST  = AW'(OFF_RST);
   localparam logic [AW-1:0] A_BCFG = AW'(OFF_BCFG);
   localparam logic [31:0]   ID_WORD = {4'h0, PART_CODE, ID_TAG};

   if (DW != 16) begin : g_bad_dw
      $error("regwin_ctl: DW must be 16");
   end
   if (AW < 5) begin : g_bad_aw
      $error("regwin_ctl: AW too small for port offsets");
   end
   if (IDX_W < 7) begin : g_bad_idx
      $error("regwin_ctl: IDX_W must reach index 89");
   end
   if (BCR_COUNT < 1 || BCR_COUNT > (1 << IDX_W)) begin : g_bad_bcr
      $error("regwin_ctl: BCR_COUNT out of range");
   end

   logic [IDX_W-1:0] idx_q;
   logic [DW-1:0]    adr_lo, adr_hi, bcr_rdata, csr_rdata;
   logic             wr_data, wr_idx, wr_bcfg, soft_rst, wr_main, idon;
   run_state_t       state;

   assign wr_data  = sel && wr && addr == A_DATA;
   assign wr_idx   = sel && wr && addr == A_IDX;
   assign wr_bcfg  = sel && wr && addr == A_BCFG;
   assign soft_rst = sel && rd && addr == A_RST;
   assign wr_main  = wr_data && idx_q == IDX_W'(CR_MAIN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q  <= '0;
         adr_lo <= '0;
         adr_hi <= '0;
      end else begin
         if (wr_idx) idx_q <= wdata[IDX_W-1:0];
         if (wr_data && idx_q == IDX_W'(CR_ADRLO)) adr_lo <= wdata;
         if (wr_data && idx_q == IDX_W'(CR_ADRHI)) adr_hi <= wdata;
      end
   end

   rw_run_ctl u_run (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_wr(wr_main),
      .cmd_init(wdata[B_INIT]), .cmd_strt(wdata[B_STRT]),
      .cmd_stop(wdata[B_STOP]), .cmd_tdmd(wdata[B_TDMD]),
      .cmd_idclr(wdata[B_IDON]), .init_ack(init_ack), .state(state),
      .idon(idon), .init_req(init_req), .run(run), .tx_demand(tx_demand)
   );

   rw_bcr_bank #(.DW(DW), .IDX_W(IDX_W), .BCR_COUNT(BCR_COUNT)) u_bcr (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_bcfg), .idx(idx_q),
      .wdata(wdata), .rdata(bcr_rdata)
   );

   always_comb begin
      csr_rdata = '0;
      case (idx_q)
         IDX_W'(CR_MAIN): begin
            csr_rdata[B_INIT] = (state == RS_INIT);
            csr_rdata[B_STRT] = (state == RS_RUN);
            csr_rdata[B_STOP] = (state == RS_STOP);
            csr_rdata[B_IDON] = idon;
         end
         IDX_W'(CR_ADRLO): csr_rdata = adr_lo;
         IDX_W'(CR_ADRHI): csr_rdata = adr_hi;
         IDX_W'(CR_IDLO):  csr_rdata = ID_WORD[15:0];
         IDX_W'(CR_IDHI):  csr_rdata = ID_WORD[31:16];
         default:          csr_rdata = '0;
      endcase
   end

   always_comb begin
      rdata = '0;
      if (sel && rd) begin
         if (addr == A_DATA)      rdata = csr_rdata;
         else if (addr == A_IDX)  rdata = DW'(idx_q);
         else if (addr == A_BCFG) rdata = bcr_rdata;
      end
   end

   assign init_addr = {adr_hi, adr_lo};
endmodule

// File: rtl/rw_chk.sv
module rw_chk #(
   parameter int AW    = 5,
   parameter int IDX_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             sel,
   input logic             wr,
   input logic             rd,
   input logic [AW-1:0]    addr,
   input logic             stop_bit,
   input logic             tdmd_bit,
   input logic [IDX_W-1:0] idx_q,
   input logic             init_req,
   input logic             init_ack,
   input logic             run,
   input logic             tx_demand
);
   localparam logic [AW-1:0] A_DATA = AW'(rw_pkg::OFF_DATA);
   localparam logic [AW-1:0] A_RST  = AW'(rw_pkg::OFF_RST);

   logic main_wr;
   assign main_wr = sel && wr && addr == A_DATA && idx_q == '0;

   // R7
   txd_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_demand |-> $past(run));
   // R7
   txd_needs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_demand |-> $past(main_wr && tdmd_bit));
   // R3
   req_run_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(init_req && run));
   // R4
   req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (init_req && init_ack) |=> !init_req);
   // R8
   stop_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (main_wr && stop_bit) |=> (!run && !init_req));
   // R11
   soft_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && rd && addr == A_RST) |=> (!run && !init_req && !tx_demand));
endmodule

bind regwin_ctl rw_chk #(.AW(AW), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rd(rd), .addr(addr),
   .stop_bit(wdata[2]), .tdmd_bit(wdata[3]), .idx_q(idx_q),
   .init_req(init_req), .init_ack(init_ack), .run(run), .tx_demand(tx_demand)
);

// File: tb/sim_regwin_ctl.sv
module sim_regwin_ctl;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 5, DW = 16, IDX_W = 7, BCR_COUNT = 34;
   localparam logic [15:0] PART = 16'h2625;
   localparam logic [AW-1:0] P_DATA = 5'h10, P_IDX = 5'h12, P_RST = 5'h14, P_BCFG = 5'h16;

   logic clk = 0, rst_n = 0, sel = 0, wr = 0, rd = 0, init_ack = 0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0, rdata;
   logic init_req, run, tx_demand;
   logic [2*DW-1:0] init_addr;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   regwin_ctl #(.DW(DW), .AW(AW), .IDX_W(IDX_W), .BCR_COUNT(BCR_COUNT),
                .PART_CODE(PART)) u0 (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .rd(rd), .addr(addr),
      .wdata(wdata), .rdata(rdata), .init_ack(init_ack), .init_req(init_req),
      .init_addr(init_addr), .run(run), .tx_demand(tx_demand));

   function automatic logic [15:0] exp_id(input bit hi);
      logic [31:0] w = {4'h0, PART, 12'h003};
      return hi ? w[31:16] : w[15:0];
   endfunction

   function automatic logic [15:0] exp_main(input bit stp, input bit ini,
                                            input bit rn, input bit idn);
      return {7'b0, idn, 5'b0, stp, rn, ini};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr_port(input logic [AW-1:0] a, input logic [15:0] d);
      @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d;
      @(negedge clk); sel = 0; wr = 0;
   endtask

   task automatic rd_port(input logic [AW-1:0] a, output logic [15:0] d);
      @(negedge clk); sel = 1; rd = 1; addr = a;
      #1 d = rdata;
      @(negedge clk); sel = 0; rd = 0;
   endtask

   task automatic csr_wr(input int i, input logic [15:0] d);
      wr_port(P_IDX, 16'(i)); wr_port(P_DATA, d);
   endtask

   task automatic csr_rd(input int i, output logic [15:0] d);
      wr_port(P_IDX, 16'(i)); rd_port(P_DATA, d);
   endtask

   task automatic pulse_ack();
      @(negedge clk); init_ack = 1; @(negedge clk); init_ack = 0;
   endtask

   initial begin
      logic [15:0] v;
      logic [15:0] bm [BCR_COUNT];
      logic [15:0] lo_m, hi_m;
      int seed = 1234;
      void'($urandom(seed));
      repeat (4) @(negedge clk);
      rst_n = 1;
      // R2 reset state
      csr_rd(0, v); check("R2 main after reset", v, exp_main(1, 0, 0, 0));
      check("R2 outputs", {init_req, run, tx_demand}, 3'b000);
      // R1 index pointer
      wr_port(P_IDX, 16'd88); rd_port(P_IDX, v); check("R1 idx 88", v, 16'd88);
      wr_port(P_IDX, 16'hFFFF); rd_port(P_IDX, v); check("R1 idx trunc", v, 16'h007F);
      // R10 identification
      csr_rd(88, v); check("R10 id lo", v, exp_id(0));
      csr_wr(89, 16'hFFFF); csr_rd(89, v); check("R10 id hi", v, exp_id(1));
      // R13 unimplemented
      csr_wr(5, 16'hBEEF); csr_rd(5, v); check("R13 csr 5", v, 16'h0);
      wr_port(P_IDX, 16'd100); wr_port(P_BCFG, 16'h1111); rd_port(P_BCFG, v);
      check("R13 bcr 100", v, 16'h0);
      // R7 ignored when stopped
      csr_wr(0, 16'h0008); check("R7 no pulse stopped", tx_demand, 1'b0);
      rd_port(P_DATA, v); check("R7 main unchanged", v, exp_main(1, 0, 0, 0));
      // R9 init address
      csr_wr(1, 16'h1234); csr_wr(2, 16'hABCD);
      check("R9 init_addr", init_addr, 32'hABCD1234);
      csr_rd(1, v); check("R9 reg1", v, 16'h1234);
      // R3 init
      csr_wr(0, 16'h0001); check("R3 init_req", init_req, 1'b1);
      repeat (5) @(negedge clk);
      rd_port(P_DATA, v); check("R3 main initialising", v, exp_main(0, 1, 0, 0));
      // R4 ack
      pulse_ack(); check("R4 req dropped", init_req, 1'b0);
      rd_port(P_DATA, v); check("R4 idon set", v, exp_main(0, 0, 0, 1));
      // R5 write-one-to-clear
      wr_port(P_DATA, 16'h0000); rd_port(P_DATA, v); check("R5 zero keeps", v, exp_main(0, 0, 0, 1));
      wr_port(P_DATA, 16'h0100); rd_port(P_DATA, v); check("R5 one clears", v, exp_main(0, 0, 0, 0));
      // R6 start
      wr_port(P_DATA, 16'h0002); check("R6 run", run, 1'b1);
      rd_port(P_DATA, v); check("R6 main running", v, exp_main(0, 0, 1, 0));
      // R7 pulse
      wr_port(P_DATA, 16'h0008); check("R7 pulse high", tx_demand, 1'b1);
      @(negedge clk); check("R7 pulse one cycle", tx_demand, 1'b0);
      // R8 priorities
      wr_port(P_DATA, 16'h0007); rd_port(P_DATA, v); check("R8 stop wins", v, exp_main(1, 0, 0, 0));
      check("R8 run low", run, 1'b0);
      wr_port(P_DATA, 16'h0003); rd_port(P_DATA, v); check("R8 init beats start", v, exp_main(0, 1, 0, 0));
      pulse_ack(); wr_port(P_DATA, 16'h0002); rd_port(P_DATA, v);
      check("R6 start from initialised", v, exp_main(0, 0, 1, 1));
      // R11 soft reset
      rd_port(P_RST, v); check("R11 reset port reads 0", v, 16'h0);
      rd_port(P_DATA, v); check("R11 main stopped", v, exp_main(1, 0, 0, 0));
      check("R11 addr kept", init_addr, 32'hABCD1234);
      // R12 bus-config reset value
      wr_port(P_IDX, 16'd33); rd_port(P_BCFG, v); check("R12 bcr reset", v, 16'h0);
      // R12 R13 R9 random
      for (int i = 0; i < BCR_COUNT; i++) bm[i] = '0;
      lo_m = 16'h1234; hi_m = 16'hABCD;
      for (int it = 0; it < 300; it++) begin
         int op = $urandom_range(0, 3);
         int ix = $urandom_range(0, BCR_COUNT + 5);
         logic [15:0] d = 16'($urandom);
         case (op)
            0: begin
               wr_port(P_IDX, 16'(ix)); wr_port(P_BCFG, d);
               if (ix < BCR_COUNT) bm[ix] = d;
            end
            1: begin
               wr_port(P_IDX, 16'(ix)); rd_port(P_BCFG, v);
               check(ix < BCR_COUNT ? "R12 bcr rand" : "R13 bcr rand", v,
                     ix < BCR_COUNT ? bm[ix] : 16'h0);
            end
            2: begin
               if (d[0]) begin csr_wr(1, d); lo_m = d; end
               else begin csr_wr(2, d); hi_m = d; end
               check("R9 addr rand", init_addr, {hi_m, lo_m});
            end
            default: begin
               csr_rd(ix + 3, v); check("R13 csr rand", v, 16'h0);
            end
         endcase
      end
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule